// File: doc/BRIEF.md
# Clock Field Edit Selector with Flashing Digits

This block decides which field of a time-of-day display (seconds, minutes or hours) is being adjusted, and it makes the chosen digit pair blink. It watches one mode button. From idle, the button must be held for a full second before editing starts. Editing always starts on the seconds field. After that, every new press steps the choice from seconds to minutes to hours, and the next press goes back to idle. The press can be of any length.

The block gives two outputs. The first is a one-hot field select. The second is a display enable for each field, which the segment drivers use to blank their digits. The time value itself is never changed. The selected field blinks at 2 Hz: it is shown for 80% of each period and blanked for 20%. Unselected fields stay lit.

All cycle counts come from the clock-frequency parameter. A simulation can therefore use a slow clock with short windows. The block has no data stream, so every pin is a plain control or status level.

Top module: `field_edit_ctrl`

## Requirements
In these requirements, H = `CLK_HZ` cycles, P = `CLK_HZ/2` cycles and V = `4*P/5` cycles.

- R1: While reset is active, and after it, `field_sel` is 3'b000 and `disp_en` is 3'b111.
- R2: In idle, the button level may be sampled high at H consecutive rising clock edges. After the H-th of those edges, `field_sel` becomes 3'b001. Bit 0 is seconds, bit 1 is minutes and bit 2 is hours.
- R3: In idle, a press that is sampled high at fewer than H edges leaves `field_sel` at 3'b000.
- R4: The press that enters edit mode does not also advance the selection, even if it is held well past H.
- R5: In edit mode, each 0-to-1 change of the sampled button level moves the selection one step: 001 to 010, 010 to 100, and 100 to 000 (idle). The step takes effect after the edge at which the high level is first sampled, whatever the length of the press. Between steps the selection does not change.
- R6: A press that returns the block to idle does not enter edit mode again, however long it is held.
- R7: The enable bit of the selected field is high for V cycles and then low for P-V cycles, and this pattern repeats.
- R8: The enable bit of every unselected field is always high. In idle, all three enable bits are high.
- R9: Whenever `field_sel` changes, the flash pattern restarts at the start of its visible portion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its frequency is given by `CLK_HZ` |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_btn | input | 1 | Mode button level (1 = pressed), already synchronized and debounced |
| field_sel | output | 3 | One-hot edited field: bit 0 seconds, bit 1 minutes, bit 2 hours; 0 in idle |
| disp_en | output | 3 | Display enable for each field, same bit order; 0 blanks that digit pair |

## Verification
Two events can land on the same clock edge: a selection step and a phase boundary of the blink counter. The step may come during the blank window, or on the edge where the phase would wrap. In both cases the restart must win, and the newly selected field must be shown at once. The bench times its presses so that they land inside the blank window and at the end of a period. A behavioural reference model, clocked on every edge, predicts the select and enable values. This shows whether the restart took priority over the normal phase count. A second overlap happens when the one-second hold completes while the button is still high. The bench holds the button long past that point to show that entry and stepping are not both applied.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_SEC  = 2'd1,
    SEL_MIN  = 2'd2,
    SEL_HR   = 2'd3
  } sel_state_t;

  localparam int FIELD_CNT = 3;

  function automatic logic [FIELD_CNT-1:0] state_to_onehot(sel_state_t s);
    logic [FIELD_CNT-1:0] oh;
    oh = '0;
    case (s)
      SEL_SEC: oh[0] = 1'b1;
      SEL_MIN: oh[1] = 1'b1;
      SEL_HR:  oh[2] = 1'b1;
      default: oh = '0;
    endcase
    return oh;
  endfunction
endpackage

// File: rtl/fe_edge_det.sv
module fe_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i && !lvl_q;
endmodule

// File: rtl/fe_hold_timer.sv
module fe_hold_timer #(
  parameter int HOLD_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic arm_i,
  output logic done_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(HOLD_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  // A press that starts outside idle saturates the count, so it can never fire.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!lvl_i)         cnt_q <= '0;
    else if (!arm_i)         cnt_q <= CNT_MAX;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = lvl_i && arm_i && (cnt_q == CNT_LAST);
endmodule

// File: rtl/fe_flash_gen.sv
module fe_flash_gen #(
  parameter int PERIOD = 25_000_000,
  parameter int ON_CYC = 20_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic visible_o
);
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PERIOD - 1);
  localparam logic [PW-1:0] PH_ON   = PW'(ON_CYC);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ph_q <= '0;
    else if (restart_i)      ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                     ph_q <= ph_q + 1'b1;
  end

  assign visible_o = (ph_q < PH_ON);
endmodule

// File: rtl/fe_sel_fsm.sv
module fe_sel_fsm
  import fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_i,
  input  logic       long_i,
  output sel_state_t state_o,
  output logic       change_o
);
  sel_state_t state_q, state_n;

  always_comb begin
    state_n = state_q;
    case (state_q)
      SEL_IDLE: if (long_i) state_n = SEL_SEC;
      SEL_SEC:  if (rise_i) state_n = SEL_MIN;
      SEL_MIN:  if (rise_i) state_n = SEL_HR;
      SEL_HR:   if (rise_i) state_n = SEL_IDLE;
      default:  state_n = SEL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEL_IDLE;
    else        state_q <= state_n;
  end

  assign state_o  = state_q;
  assign change_o = (state_n != state_q);
endmodule

// File: rtl/field_edit_ctrl.sv
module field_edit_ctrl
  import fe_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_btn,
  output logic [FIELD_CNT-1:0] field_sel,
  output logic [FIELD_CNT-1:0] disp_en
);
  localparam int HOLD_CYC  = CLK_HZ;
  localparam int FLASH_PER = CLK_HZ / 2;
  localparam int FLASH_ON  = (FLASH_PER * 4) / 5;

  logic       rise, long_hit, sel_change, visible;
  sel_state_t state;

  fe_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (mode_btn),
    .rise_o (rise)
  );

  fe_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (mode_btn),
    .arm_i  (state == SEL_IDLE),
    .done_o (long_hit)
  );

  fe_sel_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (rise),
    .long_i   (long_hit),
    .state_o  (state),
    .change_o (sel_change)
  );

  fe_flash_gen #(.PERIOD(FLASH_PER), .ON_CYC(FLASH_ON)) u_flash (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (sel_change),
    .visible_o (visible)
  );

  assign field_sel = state_to_onehot(state);

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_field_en
    assign disp_en[g] = !field_sel[g] || visible;
  end
endmodule

// File: rtl/fe_checker.sv
module fe_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_btn,
  input logic [2:0] field_sel,
  input logic [2:0] disp_en
);
  assert_onehot_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(field_sel));

  assert_idle_all_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (field_sel == 3'b000) |-> (disp_en == 3'b111));

  assert_unselected_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((disp_en | field_sel) == 3'b111));

  assert_restart_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (field_sel != $past(field_sel)) |-> (disp_en == 3'b111));

  assert_entry_is_seconds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (field_sel == 3'b000) |=> (field_sel == 3'b000 || field_sel == 3'b001));

  assert_step_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (field_sel != 3'b000 && $rose(mode_btn)) |=> (field_sel != $past(field_sel)));

  assert_hold_without_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (field_sel != 3'b000 && !$rose(mode_btn)) |=> $stable(field_sel));
endmodule

bind field_edit_ctrl fe_checker u_fe_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_btn  (mode_btn),
  .field_sel (field_sel),
  .disp_en   (disp_en)
);

// File: tb/field_edit_ctrl_tb_top.sv
module field_edit_ctrl_tb_top;
  localparam int HZ   = 20;
  localparam int HOLD = HZ;
  localparam int PER  = HZ / 2;
  localparam int ON   = (PER * 4) / 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_btn = 1'b0;
  logic [2:0] field_sel, disp_en;

  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  field_edit_ctrl #(.CLK_HZ(HZ)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_btn  (mode_btn),
    .field_sel (field_sel),
    .disp_en   (disp_en)
  );

  task automatic check(string t, logic [2:0] act, logic [2:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", t, $time, act, exp);
    end
  endtask

  // Behavioural reference model
  int st = 0, held = 0, ph = 0, prev_st;
  bit pb = 0, began_idle = 0, b, rise;

  always @(posedge clk) begin
    if (!rst_n) begin
      st = 0; held = 0; ph = 0; pb = 0; began_idle = 0;
    end else begin
      b = mode_btn;
      rise = b && !pb;
      prev_st = st;
      if (rise) begin began_idle = (st == 0); held = 1; end
      else if (b) held++;
      else held = 0;
      if (st == 0) begin
        if (b && began_idle && held == HOLD) st = 1;
      end else if (rise) st = (st == 3) ? 0 : st + 1;
      ph = (st != prev_st) ? 0 : (ph + 1) % PER;
      pb = b;
    end
    #5;
    if (rst_n && !done) begin
      logic [2:0] es, ee;
      es = (st == 0) ? 3'b000 : 3'(1 << (st - 1));
      ee = ~es | {3{ph < ON}};
      check({tag, " sel"}, field_sel, es);
      check({tag, " en"},  disp_en,  ee);
    end
  end

  task automatic idle_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(int n);
    @(negedge clk) mode_btn = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk) mode_btn = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #15;
    check("R1 sel in reset", field_sel, 3'b000);
    check("R1 en in reset", disp_en, 3'b111);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle_cycles(5);
    check("R1 sel after reset", field_sel, 3'b000);
    tag = "R3"; press(HOLD - 1); idle_cycles(3);
    check("R3 short hold ignored", field_sel, 3'b000);
    tag = "R2_R4"; press(2 * HOLD + 7); idle_cycles(1);
    check("R4 entry press not stepped", field_sel, 3'b001);
    tag = "R7"; idle_cycles(3 * PER + 2);
    tag = "R5"; press(1); idle_cycles(6);
    check("R5 step to minutes", field_sel, 3'b010);
    // press lands in blank window: restart must win
    tag = "R9"; idle_cycles(ON - 6); press(3); idle_cycles(PER - 2);
    check("R9 step to hours", field_sel, 3'b100);
    tag = "R6"; press(2 * HOLD + 3); idle_cycles(4);
    check("R6 exit held long stays idle", field_sel, 3'b000);
    tag = "R2"; press(HOLD); idle_cycles(PER - 1);
    check("R2 exact hold enters seconds", field_sel, 3'b001);
    tag = "R8"; press(2); idle_cycles(4); press(1); idle_cycles(PER);
    tag = "R5_wrap"; press(5); idle_cycles(3);
    check("R5 wrap to idle", field_sel, 3'b000);
    check("R8 idle all enabled", disp_en, 3'b111);
    idle_cycles(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule